// File: doc/BRIEF.md
# Priority Crossbar Pin Assigner

This block connects a fixed set of internal peripheral signals to a bank of eight shared I/O pins. No pin is hard-wired to a peripheral. Software enables whole peripheral groups and marks pins to keep out of the crossbar. A decoder then packs the enabled groups onto the remaining pins. It works in a fixed order of priority, and each group takes the lowest-numbered free pins. Pins that no group claims act as general-purpose I/O, driven from a port latch register.

Each pin has a drive-mode bit that selects push-pull or open-drain. Peripheral inputs read the level of the pin they were given. An input with no pin reads an idle 1. Reading the latch address always returns the live pin levels, whatever the crossbar holds. All configuration goes through a small synchronous register port. The pin map is worked out combinationally from the stored configuration, so it follows a write in the same cycle that the register updates. There is no streaming data path: the register port and the pins are plain control signals with no valid/ready handshake and no back-pressure.

Top module: `xbar_pin_assigner`

## Requirements
- R1: After reset the mode, skip and enable registers read 0, the latch register holds 8'hFF, and every pin has pin_oe = 0 and pin_out = 0.
- R2: The enable register (address 3) has these group bits: bit 0 serial port (transmit, receive), bit 1 two-wire bus (data, clock), bit 2 comparator (sync, async), bit 3 clock output, bit 4 capture/compare (PCA_CH channels), bit 5 timer inputs (t0, t1). Bit 7 is the global enable. Groups are packed in that bit order, highest priority first. Each group takes consecutive free pins in ascending pin order.
- R3: A set bit in the skip register (address 2) removes that pin from packing. The decoder passes over it, and the pin stays general-purpose I/O.
- R4: A group that does not fit in the remaining free pins is left unassigned and sets status bit 0 (address 4). Lower-priority groups still try to fit into the pins that are left.
- R5: While the global enable is set, a pin with no assigned signal is driven from its bit in the latch register (address 0).
- R6: Drive mode register (address 1): bit = 1 means push-pull, which gives pin_oe = 1 and pin_out = value. Bit = 0 means open-drain, which gives pin_out = 0 and pin_oe = ~value. A pin assigned to an input-only signal (serial receive, t0, t1) has pin_oe = 0. pin_out is always 0 whenever pin_oe is 0.
- R7: While the global enable bit is clear, no group is assigned, pin_oe is 0 on every pin and the overflow flag reads 0.
- R8: periph_in[s] equals pin_in at the pin assigned to signal s, and reads 1 while s is unassigned. Signal indices follow the priority order: 0 tx, 1 rx, 2 data, 3 clock, 4 cmp sync, 5 cmp async, 6 clock out, 7 to 6+PCA_CH capture/compare, then t0, t1.
- R9: A read of address 0 returns pin_in. Addresses 1 to 3 return the stored values. Writes to address 4 or above are ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data (combinational) |
| periph_out | input | NSIG | Output value from each peripheral signal |
| periph_in | output | NSIG | Pin level fed back to each peripheral signal |
| pin_in | input | 8 | Sampled pad levels |
| pin_out | output | 8 | Pad output data |
| pin_oe | output | 8 | Pad output enable |

## Verification
The assertions check the following on every cycle:
- Every pin is released while the global enable is clear.
- Open-drain pins never drive high, and no pin drives a value while its enable is low.
- Skipped push-pull pins carry their latch bit.
- Unassigned peripheral inputs idle at 1.
- The latch address reads back the live pins.

Only the bench scenarios can show where each group actually lands. That covers the priority packing order, passing over skipped pins, the overflow case where a large group fails but a later small group still fits, and the exact pin levels under mixed drive modes.

// File: rtl/xbar_pkg.sv
package xbar_pkg;

  localparam int NPIN = 8;
  localparam int PW   = $clog2(NPIN);
  localparam int NGRP = 6;
  localparam int GLOBAL_EN_BIT = 7;

  typedef enum logic [2:0] {
    ADDR_LATCH = 3'd0,
    ADDR_MODE  = 3'd1,
    ADDR_SKIP  = 3'd2,
    ADDR_EN    = 3'd3,
    ADDR_STAT  = 3'd4
  } reg_addr_e;

  // Signal count of each group, in priority order.
  function automatic int grp_size(input int g, input int pca);
    int r;
    case (g)
      3:       r = 1;
      4:       r = pca;
      default: r = 2;
    endcase
    return r;
  endfunction

  function automatic int sig_group(input int s, input int pca);
    int acc;
    int r;
    acc = 0;
    r   = NGRP - 1;
    for (int g = NGRP - 1; g >= 0; g--) begin
      acc = 0;
      for (int h = 0; h < g; h++) acc += grp_size(h, pca);
      if (s >= acc && r == NGRP - 1 && g != NGRP - 1) r = g;
      if (s >= acc && g == NGRP - 1) r = g;
      if (s >= acc) break;
    end
    return r;
  endfunction

  function automatic int sig_offset(input int s, input int pca);
    int acc;
    int g;
    g   = sig_group(s, pca);
    acc = 0;
    for (int h = 0; h < NGRP; h++) if (h < g) acc += grp_size(h, pca);
    return s - acc;
  endfunction

  // Serial receive and the two timer inputs never drive their pin.
  function automatic bit sig_is_input(input int s, input int pca);
    return (s == 1) || (s >= 7 + pca);
  endfunction

endpackage

// File: rtl/xbar_regs.sv
module xbar_regs
  import xbar_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            reg_we,
  input  logic [2:0]      reg_addr,
  input  logic [7:0]      reg_wdata,
  output logic [7:0]      reg_rdata,
  input  logic [NPIN-1:0] pin_in,
  input  logic            overflow,
  output logic [NPIN-1:0] latch_q,
  output logic [NPIN-1:0] mode_q,
  output logic [NPIN-1:0] skip_q,
  output logic [7:0]      en_q
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      latch_q <= '1;
      mode_q  <= '0;
      skip_q  <= '0;
      en_q    <= '0;
    end else if (reg_we) begin
      case (reg_addr)
        ADDR_LATCH: latch_q <= reg_wdata;
        ADDR_MODE:  mode_q  <= reg_wdata;
        ADDR_SKIP:  skip_q  <= reg_wdata;
        ADDR_EN:    en_q    <= reg_wdata;
        default:    ;
      endcase
    end
  end

  always_comb begin
    case (reg_addr)
      ADDR_LATCH: reg_rdata = pin_in;
      ADDR_MODE:  reg_rdata = mode_q;
      ADDR_SKIP:  reg_rdata = skip_q;
      ADDR_EN:    reg_rdata = en_q;
      ADDR_STAT:  reg_rdata = {7'd0, overflow};
      default:    reg_rdata = '0;
    endcase
  end

endmodule

// File: rtl/xbar_decoder.sv
module xbar_decoder
  import xbar_pkg::*;
#(
  parameter int PCA_CH = 3,
  localparam int NSIG = 9 + PCA_CH,
  localparam int SW   = $clog2(NSIG)
)(
  input  logic            glob_en,
  input  logic [NGRP-1:0] grp_en,
  input  logic [NPIN-1:0] skip,
  output logic [NSIG-1:0] sig_ok,
  output logic [PW-1:0]   sig_pin [NSIG],
  output logic [NPIN-1:0] pin_hit,
  output logic [SW-1:0]   pin_sig [NPIN],
  output logic            overflow
);

  int              rank [NPIN];
  int              base [NGRP];
  logic [NGRP-1:0] grp_ok;

  always_comb begin
    int free_cnt;
    int cursor;
    int g;
    int tgt;

    // Rank each non-skipped pin by position among the free pins.
    free_cnt = 0;
    for (int p = 0; p < NPIN; p++) begin
      rank[p] = free_cnt;
      if (!skip[p]) free_cnt++;
    end

    // Place whole groups in priority order; a misfit is passed over.
    cursor   = 0;
    overflow = 1'b0;
    for (int k = 0; k < NGRP; k++) begin
      base[k]   = 0;
      grp_ok[k] = 1'b0;
      if (glob_en && grp_en[k]) begin
        if (cursor + grp_size(k, PCA_CH) <= free_cnt) begin
          grp_ok[k] = 1'b1;
          base[k]   = cursor;
          cursor    = cursor + grp_size(k, PCA_CH);
        end else begin
          overflow = 1'b1;
        end
      end
    end

    for (int s = 0; s < NSIG; s++) begin
      sig_ok[s]  = 1'b0;
      sig_pin[s] = '0;
      g   = sig_group(s, PCA_CH);
      tgt = base[g] + sig_offset(s, PCA_CH);
      for (int p = 0; p < NPIN; p++) begin
        if (grp_ok[g] && !skip[p] && rank[p] == tgt) begin
          sig_ok[s]  = 1'b1;
          sig_pin[s] = PW'(p);
        end
      end
    end

    for (int p = 0; p < NPIN; p++) begin
      pin_hit[p] = 1'b0;
      pin_sig[p] = '0;
      for (int s = 0; s < NSIG; s++) begin
        if (sig_ok[s] && sig_pin[s] == PW'(p)) begin
          pin_hit[p] = 1'b1;
          pin_sig[p] = SW'(s);
        end
      end
    end
  end

endmodule

// File: rtl/xbar_pinmux.sv
module xbar_pinmux (
  input  logic glob_en,
  input  logic hit,
  input  logic sig_val,
  input  logic sig_input,
  input  logic latch_bit,
  input  logic push_pull,
  output logic pad_out,
  output logic pad_oe
);

  logic value;
  logic drivable;

  always_comb begin
    value    = hit ? sig_val : latch_bit;
    drivable = glob_en && !(hit && sig_input);
    if (push_pull) begin
      pad_oe  = drivable;
      pad_out = drivable && value;
    end else begin
      pad_oe  = drivable && !value;
      pad_out = 1'b0;
    end
  end

endmodule

// File: rtl/xbar_pin_assigner.sv
module xbar_pin_assigner
  import xbar_pkg::*;
#(
  parameter int PCA_CH = 3,
  localparam int NSIG = 9 + PCA_CH,
  localparam int SW   = $clog2(NSIG)
)(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            reg_we,
  input  logic [2:0]      reg_addr,
  input  logic [7:0]      reg_wdata,
  output logic [7:0]      reg_rdata,
  input  logic [NSIG-1:0] periph_out,
  output logic [NSIG-1:0] periph_in,
  input  logic [7:0]      pin_in,
  output logic [7:0]      pin_out,
  output logic [7:0]      pin_oe
);

  logic [NPIN-1:0] latch_q, mode_q, skip_q;
  logic [7:0]      en_q;
  logic            glob_en;
  logic            overflow;
  logic [NSIG-1:0] sig_ok;
  logic [PW-1:0]   sig_pin [NSIG];
  logic [NPIN-1:0] pin_hit;
  logic [SW-1:0]   pin_sig [NPIN];
  logic [NSIG-1:0] sig_in_mask;

  assign glob_en = en_q[GLOBAL_EN_BIT];

  xbar_regs u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_we    (reg_we),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .pin_in    (pin_in),
    .overflow  (overflow),
    .latch_q   (latch_q),
    .mode_q    (mode_q),
    .skip_q    (skip_q),
    .en_q      (en_q)
  );

  xbar_decoder #(.PCA_CH(PCA_CH)) u_dec (
    .glob_en  (glob_en),
    .grp_en   (en_q[NGRP-1:0]),
    .skip     (skip_q),
    .sig_ok   (sig_ok),
    .sig_pin  (sig_pin),
    .pin_hit  (pin_hit),
    .pin_sig  (pin_sig),
    .overflow (overflow)
  );

  for (genvar s = 0; s < NSIG; s++) begin : g_sig
    assign sig_in_mask[s] = sig_is_input(s, PCA_CH);
    assign periph_in[s]   = sig_ok[s] ? pin_in[sig_pin[s]] : 1'b1;
  end

  for (genvar p = 0; p < NPIN; p++) begin : g_pin
    xbar_pinmux u_mux (
      .glob_en   (glob_en),
      .hit       (pin_hit[p]),
      .sig_val   (periph_out[pin_sig[p]]),
      .sig_input (sig_in_mask[pin_sig[p]]),
      .latch_bit (latch_q[p]),
      .push_pull (mode_q[p]),
      .pad_out   (pin_out[p]),
      .pad_oe    (pin_oe[p])
    );
  end

endmodule

// File: rtl/xbar_pin_assigner_chk.sv
module xbar_pin_assigner_chk #(
  parameter int NSIG = 12
)(
  input logic            clk,
  input logic            rst_n,
  input logic            reg_we,
  input logic [2:0]      reg_addr,
  input logic [7:0]      reg_wdata,
  input logic [7:0]      reg_rdata,
  input logic [7:0]      pin_in,
  input logic [7:0]      pin_out,
  input logic [7:0]      pin_oe,
  input logic [NSIG-1:0] periph_in,
  input logic            glob_en,
  input logic [7:0]      skip_q,
  input logic [7:0]      mode_q,
  input logic [7:0]      latch_q,
  input logic [NSIG-1:0] sig_ok
);

  // R7: the whole bank is released while the crossbar is off
  a_r7_bank_released: assert property (@(posedge clk) disable iff (!rst_n)
    !glob_en |-> pin_oe == 8'h00);

  // R9: latch address always shows live pad levels
  a_r9_latch_readback: assert property (@(posedge clk) disable iff (!rst_n)
    reg_addr == 3'd0 |-> reg_rdata == pin_in);

  // R3: a skip write lands in the next cycle
  a_r3_skip_write: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && reg_addr == 3'd2) |=> skip_q == $past(reg_wdata));

  for (genvar p = 0; p < 8; p++) begin : g_pin_chk
    // R6: no value while undriven, and open-drain never drives high
    a_r6_undriven_low: assert property (@(posedge clk) disable iff (!rst_n)
      !pin_oe[p] |-> !pin_out[p]);
    a_r6_od_never_high: assert property (@(posedge clk) disable iff (!rst_n)
      !mode_q[p] |-> !pin_out[p]);
    // R3 / R5: skipped push-pull pin follows its latch bit
    a_r3_skip_gpio: assert property (@(posedge clk) disable iff (!rst_n)
      (glob_en && skip_q[p] && mode_q[p]) |-> (pin_oe[p] && pin_out[p] == latch_q[p]));
  end

  for (genvar s = 0; s < NSIG; s++) begin : g_sig_chk
    // R8: an unassigned input reads idle high
    a_r8_idle_high: assert property (@(posedge clk) disable iff (!rst_n)
      !sig_ok[s] |-> periph_in[s]);
  end

endmodule

bind xbar_pin_assigner xbar_pin_assigner_chk #(.NSIG(NSIG)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .reg_we    (reg_we),
  .reg_addr  (reg_addr),
  .reg_wdata (reg_wdata),
  .reg_rdata (reg_rdata),
  .pin_in    (pin_in),
  .pin_out   (pin_out),
  .pin_oe    (pin_oe),
  .periph_in (periph_in),
  .glob_en   (glob_en),
  .skip_q    (skip_q),
  .mode_q    (mode_q),
  .latch_q   (latch_q),
  .sig_ok    (sig_ok)
);

// File: tb/xbar_pin_assigner_bench.sv
module xbar_pin_assigner_bench;

  localparam int NSIG = 12;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            reg_we = 1'b0;
  logic [2:0]      reg_addr = '0;
  logic [7:0]      reg_wdata = '0;
  logic [7:0]      reg_rdata;
  logic [NSIG-1:0] periph_out = 12'h35B;
  logic [NSIG-1:0] periph_in;
  logic [7:0]      pin_in = '0;
  logic [7:0]      pin_out;
  logic [7:0]      pin_oe;

  int n_tests = 0;
  int n_fail  = 0;

  always #2 clk = ~clk;

  xbar_pin_assigner u_xbar_pin_assigner (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .periph_out(periph_out),
    .periph_in(periph_in), .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe)
  );

  // {enable, skip, mode, latch, expected pin_out, expected pin_oe, expected overflow}
  // periph_out = 12'h35B: tx1 rx1 dat0 clk1 cs1 ca0 clko1 pca 0,1,1 t0 0 t1 0
  localparam logic [48:0] VECS [7] = '{
    {8'h81, 8'h00, 8'hFF, 8'h00, 8'h01, 8'hFD, 1'b0},  // serial port only
    {8'hBF, 8'h00, 8'hFF, 8'h00, 8'h59, 8'hFD, 1'b1},  // all groups, capture/compare + timers misfit
    {8'hB0, 8'h05, 8'hFF, 8'hFF, 8'h9D, 8'h9F, 1'b0},  // skip pins 0,2
    {8'h88, 8'h01, 8'h00, 8'hAA, 8'h00, 8'h55, 1'b0},  // open-drain everywhere
    {8'h3F, 8'h00, 8'hFF, 8'hFF, 8'h00, 8'h00, 1'b0},  // global enable clear
    {8'hB9, 8'hE0, 8'hFF, 8'h00, 8'h05, 8'hE5, 1'b1},  // misfit then later fit
    {8'h86, 8'h00, 8'h0F, 8'h30, 8'h06, 8'hCF, 1'b0}   // mixed drive modes
  };

  function automatic string vec_tag(input int i);
    case (i)
      0: return "R2 R5";
      1: return "R2 R4";
      2: return "R3";
      3: return "R6";
      4: return "R7";
      5: return "R4";
      default: return "R6";
    endcase
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd_check(input string req, input logic [2:0] a, input logic [7:0] exp);
    reg_addr = a;
    #1;
    check(req, reg_rdata, exp);
  endtask

  task automatic config_set(input logic [7:0] en, input logic [7:0] sk,
                            input logic [7:0] md, input logic [7:0] la);
    wr(3'd0, la);
    wr(3'd1, md);
    wr(3'd2, sk);
    wr(3'd3, en);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin : main
    repeat (3) @(negedge clk);
    // R1: state during and right after reset
    check("R1 oe", pin_oe, 8'h00);
    check("R1 out", pin_out, 8'h00);
    rst_n = 1'b1;
    @(negedge clk);
    rd_check("R1 mode", 3'd1, 8'h00);
    rd_check("R1 skip", 3'd2, 8'h00);
    rd_check("R1 en", 3'd3, 8'h00);
    rd_check("R1 status", 3'd4, 8'h00);
    // R1 latch reset value observed through GPIO drive (R5)
    wr(3'd1, 8'hFF);
    wr(3'd3, 8'h80);
    #1;
    check("R1 latch", pin_out, 8'hFF);
    check("R5 gpio oe", pin_oe, 8'hFF);

    for (int i = 0; i < 7; i++) begin
      config_set(VECS[i][48:41], VECS[i][40:33], VECS[i][32:25], VECS[i][24:17]);
      #1;
      check(vec_tag(i), pin_out, VECS[i][16:9]);
      check(vec_tag(i), pin_oe, VECS[i][8:1]);
      rd_check(vec_tag(i), 3'd4, {7'd0, VECS[i][0]});
    end

    // R8: feedback through the serial-port-only map
    config_set(8'h81, 8'h00, 8'hFF, 8'h00);
    pin_in = 8'h00;
    #1;
    check("R8 rx low", periph_in[1], 1'b0);
    check("R8 t0 idle", periph_in[10], 1'b1);
    check("R8 dat idle", periph_in[2], 1'b1);
    pin_in = 8'h02;
    #1;
    check("R8 rx high", periph_in[1], 1'b1);

    // R8: timers land on pins 5 and 6 with pins 0,2 skipped
    config_set(8'hB0, 8'h05, 8'hFF, 8'hFF);
    pin_in = 8'h20;
    #1;
    check("R8 t0", periph_in[10], 1'b1);
    check("R8 t1", periph_in[11], 1'b0);
    pin_in = 8'h40;
    #1;
    check("R8 t0b", periph_in[10], 1'b0);
    check("R8 t1b", periph_in[11], 1'b1);
    check("R8 pca0", periph_in[7], 1'b0);

    // R9: live readback and ignored status write
    pin_in = 8'h5A;
    rd_check("R9 readback", 3'd0, 8'h5A);
    wr(3'd4, 8'hFF);
    rd_check("R9 status ro", 3'd4, 8'h00);
    wr(3'd6, 8'hFF);
    rd_check("R9 skip kept", 3'd2, 8'h05);

    // R2: a peripheral output change shows on its pin (pca1 at pin 3)
    periph_out[8] = 1'b0;
    #1;
    check("R2 pca follow", pin_out[3], 1'b0);

    // R7: clearing global enable drops the overflow flag
    config_set(8'hBF, 8'h00, 8'hFF, 8'h00);
    rd_check("R4 overflow", 3'd4, 8'h01);
    wr(3'd3, 8'h3F);
    rd_check("R7 no overflow", 3'd4, 8'h00);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule